// File: doc/BRIEF.md
# Bus-Programmed Watchdog Timer

This block is a watchdog peripheral on a byte-wide I/O register bus. Software loads a 24-bit timeout interval, picks the event that a timeout should raise, and sets an enable bit. From then on, a down counter advances once per pulse of a slow tick-enable input, nominally 32.768 kHz, or about 30.5 µs per step. Software must keep writing to a reload register. If the count runs out first, the block raises exactly one event output for one clock cycle. That output is one of ten interrupt lines, a non-maskable interrupt, or a system-reset request. The block also sets a sticky timeout flag that software can poll and clear.

The register window is seven byte addresses, starting at 0x67 by default. Offset 0 (0x67) is the reload register. Offset 1 (0x68) holds the enable in bit 6. Offset 2 (0x69) holds the event code in its low nibble. Offsets 3 to 5 (0x6A, 0x6B, 0x6C) hold the interval, least significant byte first. Offset 6 (0x6D) is the flag register, with the flag in bit 7.

An interval value N gives a timeout after N ticks. The value 0 stands for 2^24 ticks. Interval bytes written while the timer runs take effect at the next reload or enable.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset, every event output is 0, the flag reads 0, and the timer is disabled, so ticks cause no event.
- R2: A read of 0x6D returns the flag in bit 7 and zeros in bits 6:0. A read of any other address returns 0x00, including the write-only registers 0x67 to 0x6C.
- R3: The interval is the 24-bit value {0x6C, 0x6B, 0x6A}. When bit 6 of 0x68 changes from 0 to 1, the counter loads this value. The event pulse is visible in the cycle that follows the clock edge at which the N-th tick is taken, and not earlier.
- R4: While the timer is enabled, a write of any data to 0x67 reloads the full interval and restarts the count.
- R5: Writing 0 to bit 6 of 0x68 stops the timer. While it is stopped, no event occurs and the flag is not set. Enabling it again restarts from the full interval.
- R6: The low nibble of 0x69 selects the event. Codes 1 to 7 drive irqOut bits 0 to 6 (IRQ3, IRQ4, IRQ5, IRQ6, IRQ7, IRQ9, IRQ10). Codes 9, A and B drive irqOut bits 7 to 9 (IRQ12, IRQ14, IRQ15). Code C drives nmiOut and code D drives sysRstOut.
- R7: Codes 0, 8, E and F drive no event output. The flag is still set on expiry.
- R8: The event lasts exactly one clock cycle. After expiry the counter stays at zero and no further event occurs until a reload or a re-enable.
- R9: The flag is set on the cycle after the event pulse. Writing a 1 to bit 7 of 0x6D clears it. Writing 0 to that bit leaves it unchanged.
- R10: If an expiry and a clearing write of the flag happen in the same cycle, the flag stays set.
- R11: At most one event output is active in any cycle.
- R12: Writing 1 to bit 6 of 0x68 while the timer is already enabled does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-cycle count-enable pulse at the tick rate |
| busAddr | input | 8 | Register byte address |
| busWr | input | 1 | Write strobe for the current address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for busAddr |
| irqOut | output | 10 | Interrupt event lines, one-cycle pulses |
| nmiOut | output | 1 | Non-maskable interrupt event pulse |
| sysRstOut | output | 1 | System reset request pulse |

## Verification
Some properties are checked on every cycle: at most one event output is active, every event lasts one cycle, invalid codes stay silent, a disable write silences the next cycle, the flag follows its set and clear rules, and non-flag addresses read zero. Other behaviour only shows in the bench's scenarios. That covers the exact tick count to expiry, the restart on reload or enable, the lack of a restart on a repeated enable, the use of all three interval bytes, the full code-to-output map, and the tie between set and clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic run;   // timer enabled after this edge
    logic load;  // copy interval into the counter
    logic tick;  // count step
  } wdStrobe_t;

  localparam int IRQ_LINES = 10;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  wdStrobe_t        strobe,
  input  logic [CNT_W-1:0] interval,
  output logic             firePulse
);
  logic [CNT_W-1:0] count;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      armed     <= 1'b0;
      firePulse <= 1'b0;
    end else begin
      firePulse <= 1'b0;
      if (!strobe.run) begin
        armed <= 1'b0;
      end else if (strobe.load) begin
        count <= interval;
        armed <= 1'b1;
      end else if (strobe.tick && armed) begin
        count <= count - 1'b1;
        if (count == CNT_W'(1)) begin
          armed     <= 1'b0;
          firePulse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter logic [7:0] BASE  = 8'h67,
  parameter int         CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic [7:0]       busAddr,
  input  logic             busWr,
  input  logic [7:0]       busWdata,
  input  logic             firePulse,
  output wdStrobe_t        strobe,
  output logic [CNT_W-1:0] interval,
  output logic [3:0]       evtSel,
  output logic             enReg,
  output logic             fireOk,
  output logic             flagBit,
  output logic [7:0]       busRdata
);
  localparam int NBYTES   = CNT_W / 8;
  localparam int OFF_INTV = 3;
  localparam logic [7:0] A_RELOAD = BASE;
  localparam logic [7:0] A_EN     = BASE + 8'd1;
  localparam logic [7:0] A_SEL    = BASE + 8'd2;
  localparam logic [7:0] A_FLAG   = BASE + 8'(OFF_INTV + NBYTES);

  logic [7:0] intvByte [NBYTES];
  logic       wrEn, wrReload, wrSel, wrFlag, enNext;

  assign wrEn     = busWr && (busAddr == A_EN);
  assign wrReload = busWr && (busAddr == A_RELOAD);
  assign wrSel    = busWr && (busAddr == A_SEL);
  assign wrFlag   = busWr && (busAddr == A_FLAG);

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_intv
      always_ff @(posedge clk) begin
        if (rst) intvByte[g] <= '0;
        else if (busWr && busAddr == BASE + 8'(OFF_INTV + g)) intvByte[g] <= busWdata;
      end
      assign interval[8*g +: 8] = intvByte[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg   <= 1'b0;
      evtSel  <= '0;
      flagBit <= 1'b0;
    end else begin
      enReg <= enNext;
      if (wrSel) evtSel <= busWdata[3:0];
      if (fireOk) flagBit <= 1'b1;
      else if (wrFlag && busWdata[7]) flagBit <= 1'b0;
    end
  end

  always_comb begin
    enNext      = wrEn ? busWdata[6] : enReg;
    strobe.run  = enNext;
    strobe.load = (wrEn && busWdata[6] && !enReg) || (wrReload && enNext);
    strobe.tick = tickEn;
  end

  assign fireOk   = firePulse && enReg;
  assign busRdata = (busAddr == A_FLAG) ? {flagBit, 7'b0} : 8'h00;
endmodule

// File: rtl/wdog_route.sv
module wdog_route
  import wdog_pkg::*;
(
  input  logic                 fire,
  input  logic [3:0]           sel,
  output logic [IRQ_LINES-1:0] irqOut,
  output logic                 nmiOut,
  output logic                 sysRstOut
);
  always_comb begin
    irqOut    = '0;
    nmiOut    = 1'b0;
    sysRstOut = 1'b0;
    if (fire) begin
      unique case (sel)
        4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7: irqOut[sel - 4'h1] = 1'b1;
        4'h9, 4'hA, 4'hB:                         irqOut[sel - 4'h2] = 1'b1;
        4'hC:    nmiOut    = 1'b1;
        4'hD:    sysRstOut = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter logic [7:0] BASE  = 8'h67,
  parameter int         CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tickEn,
  input  logic [7:0]           busAddr,
  input  logic                 busWr,
  input  logic [7:0]           busWdata,
  output logic [7:0]           busRdata,
  output logic [IRQ_LINES-1:0] irqOut,
  output logic                 nmiOut,
  output logic                 sysRstOut
);
  wdStrobe_t        strobe;
  logic [CNT_W-1:0] interval;
  logic [3:0]       evtSel;
  logic             enReg, fireOk, flagBit, firePulse;

  wdog_ctrl #(.BASE(BASE), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .firePulse(firePulse), .strobe(strobe),
    .interval(interval), .evtSel(evtSel), .enReg(enReg), .fireOk(fireOk),
    .flagBit(flagBit), .busRdata(busRdata)
  );

  wdog_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .interval(interval),
    .firePulse(firePulse)
  );

  wdog_route u_route (
    .fire(fireOk), .sel(evtSel), .irqOut(irqOut), .nmiOut(nmiOut),
    .sysRstOut(sysRstOut)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter logic [7:0] BASE  = 8'h67,
  parameter int         CNT_W = 24
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] busAddr,
  input logic       busWr,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic [9:0] irqOut,
  input logic       nmiOut,
  input logic       sysRstOut,
  input logic [3:0] evtSel,
  input logic       fireOk,
  input logic       flagBit
);
  localparam logic [7:0] A_EN   = BASE + 8'd1;
  localparam logic [7:0] A_FLAG = BASE + 8'(3 + CNT_W / 8);
  logic [11:0] evt;
  assign evt = {sysRstOut, nmiOut, irqOut};

  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(evt));
  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst) (|evt) |=> !(|evt));
  // R7
  invalid_code_chk: assert property (@(posedge clk) disable iff (rst)
    (evtSel == 4'h0 || evtSel == 4'h8 || evtSel == 4'hE || evtSel == 4'hF) |-> (evt == '0));
  // R5
  disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr == A_EN && !busWdata[6]) |=> (evt == '0));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst) fireOk |=> flagBit);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr == A_FLAG && busWdata[7] && !fireOk) |=> !flagBit);
  // R2
  read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (busAddr != A_FLAG) |-> (busRdata == 8'h00));
endmodule

bind wdog_timer wdog_timer_chk #(.BASE(BASE), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .busRdata(busRdata), .irqOut(irqOut), .nmiOut(nmiOut), .sysRstOut(sysRstOut),
  .evtSel(evtSel), .fireOk(fireOk), .flagBit(flagBit)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [9:0] irqOut;
  logic       nmiOut, sysRstOut;
  logic [11:0] evtVec;
  int errors = 0;
  int checks = 0;

  assign evtVec = {sysRstOut, nmiOut, irqOut};
  always #2 clk = ~clk;

  wdog_timer uut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .nmiOut(nmiOut),
    .sysRstOut(sysRstOut)
  );

  typedef struct packed { logic [3:0] code; logic [11:0] exp; } vec_t;
  // R6 / R7 map: {sysRst, nmi, irq[9:0]}
  localparam vec_t VECS [16] = '{
    '{4'h0, 12'h000}, '{4'h1, 12'h001}, '{4'h2, 12'h002}, '{4'h3, 12'h004},
    '{4'h4, 12'h008}, '{4'h5, 12'h010}, '{4'h6, 12'h020}, '{4'h7, 12'h040},
    '{4'h8, 12'h000}, '{4'h9, 12'h080}, '{4'hA, 12'h100}, '{4'hB, 12'h200},
    '{4'hC, 12'h400}, '{4'hD, 12'h800}, '{4'hE, 12'h000}, '{4'hF, 12'h000}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0; busAddr = 8'h00; busWdata = 8'h00;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    busAddr = a; #1; v = busRdata;
  endtask

  task automatic setIntv(input logic [23:0] n);
    wr(8'h6A, n[7:0]); wr(8'h6B, n[15:8]); wr(8'h6C, n[23:16]);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(evtVec == 0, "R1 events after reset", evtVec, 0);
    rd(8'h6D, v); check(v == 8'h00, "R1 flag after reset", v, 0);
    ticks(3);
    check(evtVec == 0, "R1 no event while disabled", evtVec, 0);

    // R6 R7 R11: table walk, interval 3
    setIntv(24'd3);
    foreach (VECS[k]) begin
      wr(8'h69, {4'h0, VECS[k].code});
      wr(8'h68, 8'h40);
      ticks(2);
      check(evtVec == 0, "R3 early event", evtVec, 0);
      ticks(1);
      check(evtVec == VECS[k].exp, "R6/R7 event map", evtVec, VECS[k].exp);
      @(negedge clk);
      check(evtVec == 0, "R8 pulse width", evtVec, 0);
      rd(8'h6D, v); check(v == 8'h80, "R9 flag set", v, 8'h80);
      wr(8'h6D, 8'h80);
      rd(8'h6D, v); check(v == 8'h00, "R9 flag clear", v, 0);
      wr(8'h68, 8'h00);
    end

    // R2: write-only registers read zero
    wr(8'h69, 8'h01);
    for (int a = 8'h67; a <= 8'h6C; a++) begin
      rd(8'(a), v); check(v == 8'h00, "R2 write-only read", v, 0);
    end

    // R8: no repeat after expiry
    wr(8'h68, 8'h40); ticks(3);
    check(evtVec == 12'h001, "R8 first fire", evtVec, 12'h001);
    ticks(5);
    check(evtVec == 0, "R8 no repeat", evtVec, 0);
    // R9: writing 0 leaves flag; R2: bits 6:0 read zero
    wr(8'h6D, 8'h7F);
    rd(8'h6D, v); check(v == 8'h80, "R9 write 0 keeps flag / R2 low bits", v, 8'h80);
    wr(8'h6D, 8'h80); wr(8'h68, 8'h00);

    // R4: reload restarts
    setIntv(24'd5); wr(8'h68, 8'h40);
    ticks(3); wr(8'h67, 8'h5A);
    ticks(4);
    check(evtVec == 0, "R4 no event before full reload interval", evtVec, 0);
    ticks(1);
    check(evtVec == 12'h001, "R4 fire after reload", evtVec, 12'h001);
    wr(8'h6D, 8'h80); wr(8'h68, 8'h00);

    // R5: disable stops, re-enable restarts
    setIntv(24'd3); wr(8'h68, 8'h40);
    ticks(2); wr(8'h68, 8'h00);
    ticks(5);
    check(evtVec == 0, "R5 no event disabled", evtVec, 0);
    rd(8'h6D, v); check(v == 8'h00, "R5 flag stays clear", v, 0);
    wr(8'h68, 8'h40); ticks(2);
    check(evtVec == 0, "R5 restart from full", evtVec, 0);
    ticks(1);
    check(evtVec == 12'h001, "R5 fire after re-enable", evtVec, 12'h001);
    wr(8'h6D, 8'h80); wr(8'h68, 8'h00);

    // R12: repeated enable does not restart
    setIntv(24'd4); wr(8'h68, 8'h40);
    ticks(2); wr(8'h68, 8'h40); ticks(2);
    check(evtVec == 12'h001, "R12 no restart", evtVec, 12'h001);
    wr(8'h6D, 8'h80); wr(8'h68, 8'h00);

    // R3: multi-byte interval 0x000102 = 258 ticks
    setIntv(24'h000102); wr(8'h68, 8'h40);
    ticks(257);
    check(evtVec == 0, "R3 mid byte no early fire", evtVec, 0);
    ticks(1);
    check(evtVec == 12'h001, "R3 fire at 258", evtVec, 12'h001);
    wr(8'h6D, 8'h80); wr(8'h68, 8'h00);
    // R3: high byte counts (0x010001 ticks)
    setIntv(24'h010001); wr(8'h68, 8'h40);
    ticks(300);
    check(evtVec == 0, "R3 high byte extends", evtVec, 0);
    rd(8'h6D, v); check(v == 8'h00, "R3 high byte no flag", v, 0);
    wr(8'h68, 8'h00);

    // R10: set wins over clear
    setIntv(24'd1); wr(8'h68, 8'h40);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    check(evtVec == 12'h001, "R10 fire", evtVec, 12'h001);
    busAddr = 8'h6D; busWdata = 8'h80; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    rd(8'h6D, v); check(v == 8'h80, "R10 set wins", v, 8'h80);
    wr(8'h6D, 8'h80);
    rd(8'h6D, v); check(v == 8'h00, "R10 later clear", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule